// File: doc/BRIEF.md
# Master Clock Source Select Guard

This block holds the clock generator mode register: a two-bit master clock source select plus enable bits for the main oscillator and the frequency-multiplying loop. Software writes the whole register at once. Before a write lands, the block checks the requested setting against the setting now in force and against the oscillator stable and loop lock flags. A write that would break a safety rule is dropped as a unit, and the register keeps every old field.

The accepted select and enables drive the glitch-free clock multiplexer and the oscillator and loop controls, which sit outside this block. A sticky error flag records that a write was dropped. Software reads the flag through a read strobe, and the read clears it.

Top module: `clk_src_guard`

## Requirements
- R1: After reset the select is 00 (slow clock), both enables are 0 and the error flag is 0.
- R2: Write data layout: bits [1:0] select (00 slow clock, 01 main oscillator, 10 loop, 11 reserved), bit 2 oscillator enable, bit 3 loop enable. An accepted write updates all three fields on the clock edge that samples it. A write that selects 11 is rejected.
- R3: A write that moves the select from 00 to another value is rejected while the current oscillator enable is 0 or osc_stable is low.
- R4: A write that clears the loop enable while it is set is rejected when the current select is 10.
- R5: A write that selects 10 and has loop enable 0 is rejected.
- R6: A write that selects 01 or 10 and has oscillator enable 0 is rejected.
- R7: A write that clears the oscillator enable while it is set is rejected unless the current select is 00.
- R8: A write that selects 10 is rejected while loop_lock is low.
- R9: A rejected write leaves select and both enables unchanged and sets the error flag on the same edge. Without a write the fields hold.
- R10: An err_rd strobe clears the error flag on the next edge. If a rejected write occurs in the same cycle as the strobe, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Requested loop enable, oscillator enable and select |
| osc_stable | input | 1 | Main oscillator output is stable |
| loop_lock | input | 1 | Loop output is locked |
| err_rd | input | 1 | Error flag read strobe; clears the flag |
| src_sel | output | 2 | Accepted master clock source select |
| osc_on | output | 1 | Accepted oscillator enable |
| loop_on | output | 1 | Accepted loop enable |
| err_flag | output | 1 | Sticky rejected-write flag |

## Verification
The hardest situations to reach are the rules that depend on the current state, such as dropping the loop while it drives the master clock. These states can only be reached by a chain of legal writes made with the stable and lock flags high. The bench therefore brings up each of the seven legal register states with such a chain after a fresh reset. From each state it applies all sixteen write values under all four combinations of the stable and lock flags, and compares the result with an arithmetic model of the rules.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

  localparam int SEL_W  = 2;
  localparam int MODE_W = SEL_W + 2;
  localparam int RULE_N = 7;

  typedef enum logic [SEL_W-1:0] {
    SRC_SLOW = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_LOOP = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  typedef struct packed {
    logic loop_en;
    logic osc_en;
    src_e sel;
  } mode_t;

  localparam mode_t MODE_RST = '{loop_en: 1'b0, osc_en: 1'b0, sel: SRC_SLOW};

  // One bit per safety rule; any set bit drops the write.
  function automatic logic [RULE_N-1:0] rule_hits(
    input mode_t cur,
    input mode_t req,
    input logic  stable,
    input logic  lock
  );
    logic [RULE_N-1:0] h;
    h[0] = (req.sel == SRC_RSVD);
    h[1] = (cur.sel == SRC_SLOW) && (req.sel != SRC_SLOW) && (!cur.osc_en || !stable);
    h[2] = cur.loop_en && !req.loop_en && (cur.sel == SRC_LOOP);
    h[3] = (req.sel == SRC_LOOP) && !req.loop_en;
    h[4] = ((req.sel == SRC_OSC) || (req.sel == SRC_LOOP)) && !req.osc_en;
    h[5] = cur.osc_en && !req.osc_en && (cur.sel != SRC_SLOW);
    h[6] = (req.sel == SRC_LOOP) && !lock;
    return h;
  endfunction

endpackage

// File: rtl/clk_guard_rules.sv
module clk_guard_rules
  import clk_guard_pkg::*;
(
  input  mode_t             cur,
  input  mode_t             req,
  input  logic              stable,
  input  logic              lock,
  output logic [RULE_N-1:0] hits,
  output logic              reject
);
  always_comb begin
    hits   = rule_hits(cur, req, stable, lock);
    reject = |hits;
  end
endmodule

// File: rtl/clk_guard_reg.sv
module clk_guard_reg
  import clk_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t d,
  output mode_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= MODE_RST;
    else if (load) q <= d;
  end
endmodule

// File: rtl/clk_guard_err.sv
module clk_guard_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/clk_src_guard.sv
module clk_src_guard
  import clk_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic             osc_stable,
  input  logic             loop_lock,
  input  logic             err_rd,
  output logic [SEL_W-1:0] src_sel,
  output logic             osc_on,
  output logic             loop_on,
  output logic             err_flag
);
  mode_t             cur_mode;
  mode_t             req_mode;
  logic [RULE_N-1:0] rule_hit;
  logic              wr_reject;
  logic              wr_accept;
  logic              wr_drop;

  assign req_mode = mode_t'(wr_data);

  clk_guard_rules u_rules (
    .cur    (cur_mode),
    .req    (req_mode),
    .stable (osc_stable),
    .lock   (loop_lock),
    .hits   (rule_hit),
    .reject (wr_reject)
  );

  assign wr_accept = wr_en && !wr_reject;
  assign wr_drop   = wr_en && wr_reject;

  clk_guard_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_accept),
    .d     (req_mode),
    .q     (cur_mode)
  );

  clk_guard_err u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wr_drop),
    .clr   (err_rd),
    .flag  (err_flag)
  );

  assign src_sel = cur_mode.sel;
  assign osc_on  = cur_mode.osc_en;
  assign loop_on = cur_mode.loop_en;
endmodule

// File: rtl/clk_src_guard_chk.sv
module clk_src_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_data,
  input logic       osc_stable,
  input logic       loop_lock,
  input logic       err_rd,
  input logic [1:0] src_sel,
  input logic       osc_on,
  input logic       loop_on,
  input logic       err_flag,
  input logic       wr_reject
);
  // R2
  rsvd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) src_sel != 2'b11);
  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_reject) |=> ({loop_on, osc_on, src_sel} == $past(wr_data)));
  // R3
  leave_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && (!osc_on || !osc_stable)) |=> (src_sel == 2'b00));
  // R4
  loop_src_has_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b10) |-> loop_on);
  // R6
  fast_src_has_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 2'b00) |-> osc_on);
  // R8
  unlocked_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 2'b10 && !loop_lock) |=> (src_sel != 2'b10));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({loop_on, osc_on, src_sel}));
  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reject) |=> ($stable({loop_on, osc_on, src_sel}) && err_flag));
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !(wr_en && wr_reject)) |=> !err_flag);
endmodule

bind clk_src_guard clk_src_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .osc_stable (osc_stable),
  .loop_lock  (loop_lock),
  .err_rd     (err_rd),
  .src_sel    (src_sel),
  .osc_on     (osc_on),
  .loop_on    (loop_on),
  .err_flag   (err_flag),
  .wr_reject  (wr_reject)
);

// File: tb/clk_src_guard_tb.sv
module clk_src_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic       osc_stable = 1'b0;
  logic       loop_lock = 1'b0;
  logic       err_rd = 1'b0;
  logic [1:0] src_sel;
  logic       osc_on;
  logic       loop_on;
  logic       err_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_src_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .osc_stable(osc_stable), .loop_lock(loop_lock), .err_rd(err_rd),
    .src_sel(src_sel), .osc_on(osc_on), .loop_on(loop_on), .err_flag(err_flag)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Model: returns the tag of the first rule broken, or "" when the write is legal.
  function automatic string broken(input logic [3:0] c, input logic [3:0] n,
                                   input logic st, input logic lk);
    logic [1:0] cs = c[1:0], ns = n[1:0];
    if (ns == 2'd3) return "R2";
    if (cs == 2'd0 && ns != 2'd0 && (c[2] == 1'b0 || st == 1'b0)) return "R3";
    if (c[3] && !n[3] && cs == 2'd2) return "R4";
    if (ns == 2'd2 && !n[3]) return "R5";
    if (ns != 2'd0 && !n[2]) return "R6";
    if (c[2] && !n[2] && cs != 2'd0) return "R7";
    if (ns == 2'd2 && !lk) return "R8";
    return "";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    err_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
  endtask

  function automatic logic [4:0] obs();
    return {err_flag, loop_on, osc_on, src_sel};
  endfunction

  // Reach a legal state through legal writes.
  task automatic goto_state(input logic [3:0] s);
    do_reset();
    osc_stable = 1'b1;
    loop_lock = 1'b1;
    wr(4'b1100);
    wr({2'b11, s[1:0]});
    if (s[1:0] == 2'd0) wr(s);
    else if (s[1:0] == 2'd1 && !s[3]) wr(s);
    check("R2 setup", obs(), {1'b0, s});
  endtask

  initial begin
    logic [3:0] states [7];
    states = '{4'b0000, 4'b0100, 4'b1000, 4'b1100, 4'b0101, 4'b1101, 4'b1110};

    do_reset();
    check("R1", obs(), 5'b00000);

    foreach (states[i]) begin
      for (int sl = 0; sl < 4; sl++) begin
        for (int d = 0; d < 16; d++) begin
          logic [3:0] cur = states[i];
          logic [3:0] nd = 4'(d);
          string t;
          goto_state(cur);
          osc_stable = sl[0];
          loop_lock = sl[1];
          t = broken(cur, nd, sl[0], sl[1]);
          wr(nd);
          if (t == "") check("R2 accepted write", obs(), {1'b0, nd});
          else begin
            check({t, " R9 rejected write"}, obs(), {1'b1, cur});
          end
        end
      end
    end

    // R10: read clears; read with a rejected write keeps the flag.
    do_reset();
    wr(4'b0011);
    check("R9 sticky", obs(), 5'b10000);
    @(negedge clk);
    check("R9 held", obs(), 5'b10000);
    @(negedge clk);
    err_rd = 1'b1;
    wr_en = 1'b1;
    wr_data = 4'b0011;
    @(negedge clk);
    err_rd = 1'b0;
    wr_en = 1'b0;
    check("R10 set wins", obs(), 5'b10000);
    rd();
    check("R10 read clear", obs(), 5'b00000);
    wr(4'b0001);
    check("R3 leave slow osc off", obs(), 5'b10000);
    @(negedge clk);
    err_rd = 1'b1;
    wr_en = 1'b1;
    wr_data = 4'b0100;
    @(negedge clk);
    err_rd = 1'b0;
    wr_en = 1'b0;
    check("R10 clear with accepted write", obs(), 5'b00100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule